// File: doc/BRIEF.md
# Fractional Clock Enable Divider

This block paces an execution engine that runs from the system clock. It does not make a new clock. It raises a strobe, `tick`, that is one system cycle wide. The engine advances only in cycles where the strobe is high. The divisor has two parts: a 16-bit whole part `div_int` and an 8-bit fraction `div_frac`. The average spacing between strobes is `div_int + div_frac/256` system cycles.

To reach a fractional rate, the block holds an 8-bit accumulator. At the end of each period it adds the fraction to the accumulator. When that addition overflows, the next period is one cycle longer. So each period lasts either the whole part or the whole part plus one. A small whole part therefore shows visible jitter from one period to the next. A restart input re-aligns the phase and leaves the divisor untouched. A design with several channels places one of these blocks per channel.

Top module: `frac_clk_pacer`

## Requirements
- R1: With a whole part I (1 or more) and a fraction F, the k-th strobe after a restart comes exactly k*I + floor((k-1)*F/256) cycles after the restart cycle.
- R2: A divisor of whole part 1 and fraction 0 gives a strobe on every system cycle after the first.
- R3: Across any 256 consecutive periods that start from a restart, exactly F periods are one cycle longer. The distance from strobe 1 to strobe 257 is therefore 256*I + F cycles.
- R4: A whole part of 0 acts as 65536. With fraction 0, the first strobe after a restart comes after 65536 cycles, and no strobe comes before that.
- R5: A restart clears both the cycle counter and the fraction accumulator. The first strobe then comes exactly I cycles after the restart cycle. The divisor inputs are not altered.
- R6: If a restart arrives in the same cycle that a period ends, the restart wins. No strobe is given in that cycle, and the next strobe comes I cycles later.
- R7: A divisor change made in the middle of a period does not alter the period in progress. It takes effect from the next period boundary.
- R8: Synchronous reset acts like a restart. `tick` is low while reset is held, and the first strobe comes I cycles after the last reset cycle.
- R9: With a whole part of 2 or more, a strobe is always one cycle wide and never comes in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| div_int | input | 16 | Whole part of the divisor; 0 means 65536 |
| div_frac | input | 8 | Fraction of the divisor, in 1/256 steps |
| restart | input | 1 | One-cycle strobe that resets the divider phase |
| tick | output | 1 | One-cycle enable strobe for the paced engine |

## Verification
A restart and the end of a period can fall in the same cycle. The bench provokes this by running a divide-by-4 until the cycle where a strobe is due, then raising restart in exactly that cycle. The bench expects `tick` to stay low in that cycle and the next strobe to come four cycles later. A divisor change in the middle of a period is judged in the same way: the strobe at the old boundary must still appear, and the new spacing applies only after it.

// File: rtl/frac_clk_pacer_pkg.sv
package frac_clk_pacer_pkg;

    localparam int DEF_INT_W  = 16;
    localparam int DEF_FRAC_W = 8;

    // What the divider state does in a given cycle
    typedef enum logic [1:0] {
        ACT_COUNT   = 2'd0,
        ACT_RELOAD  = 2'd1,
        ACT_RESTART = 2'd2
    } pacer_act_e;

    // Restart outranks a period end; a period end outranks counting
    function automatic pacer_act_e pick_action(input logic restart, input logic expire);
        if (restart)
            return ACT_RESTART;
        else if (expire)
            return ACT_RELOAD;
        else
            return ACT_COUNT;
    endfunction

endpackage

// File: rtl/pacer_frac_accum.sv
module pacer_frac_accum
    import frac_clk_pacer_pkg::*;
#(
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  pacer_act_e        act,
    input  logic [FRAC_W-1:0] frac,
    output logic              carry
);
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W:0]   sum;

    assign sum   = {1'b0, acc_q} + {1'b0, frac};
    assign carry = sum[FRAC_W];

    always_ff @(posedge clk) begin
        if (rst || act == ACT_RESTART)
            acc_q <= '0;
        else if (act == ACT_RELOAD)
            acc_q <= sum[FRAC_W-1:0];
    end

    // R1
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_COUNT) |=> $stable(acc_q));

    // R5
    acc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (act == ACT_RESTART) |=> (acc_q == '0));

endmodule

// File: rtl/pacer_period_counter.sv
module pacer_period_counter
    import frac_clk_pacer_pkg::*;
#(
    parameter int INT_W = DEF_INT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  pacer_act_e       act,
    input  logic [INT_W-1:0] div_int,
    input  logic             carry,
    output logic             expire
);
    localparam int CNT_W = INT_W + 1;
    localparam logic [CNT_W-1:0] FULL_SPAN = {1'b1, {INT_W{1'b0}}};

    logic [CNT_W-1:0] remain_q;
    logic [CNT_W-1:0] base_len;
    logic [CNT_W-1:0] next_len;

    // Whole part of zero stands for the full 2^INT_W span
    assign base_len = (div_int == '0) ? FULL_SPAN : {1'b0, div_int};
    assign next_len = base_len + {{INT_W{1'b0}}, carry};
    assign expire   = (remain_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst || act == ACT_RESTART)
            remain_q <= base_len;
        else if (act == ACT_RELOAD)
            remain_q <= next_len;
        else
            remain_q <= remain_q - CNT_W'(1);
    end

    // R4
    remain_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        remain_q != '0);

    // R4
    remain_bound_chk: assert property (@(posedge clk) disable iff (rst)
        remain_q <= FULL_SPAN + CNT_W'(1));

endmodule

// File: rtl/frac_clk_pacer.sv
module frac_clk_pacer
    import frac_clk_pacer_pkg::*;
#(
    parameter int INT_W  = DEF_INT_W,
    parameter int FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [INT_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    input  logic              restart,
    output logic              tick
);
    pacer_act_e act;
    logic       expire;
    logic       carry;

    assign act  = pick_action(restart, expire);
    assign tick = (act == ACT_RELOAD) && !rst;

    pacer_frac_accum #(.FRAC_W(FRAC_W)) accum_i (
        .clk   (clk),
        .rst   (rst),
        .act   (act),
        .frac  (div_frac),
        .carry (carry)
    );

    pacer_period_counter #(.INT_W(INT_W)) count_i (
        .clk     (clk),
        .rst     (rst),
        .act     (act),
        .div_int (div_int),
        .carry   (carry),
        .expire  (expire)
    );

    // R2
    every_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(tick) && $past(div_int) == INT_W'(1)
         && $past(div_frac) == '0 && !restart) |-> tick);

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(tick) && $past(div_int) >= INT_W'(2)) |-> !tick);

    // R5
    restart_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (restart && div_int >= INT_W'(2)) |=> !tick);

endmodule

// File: tb/frac_clk_pacer_tb_top.sv
module frac_clk_pacer_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] div_int;
    logic [7:0]  div_frac;
    logic        restart;
    logic        tick;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #2 clk = ~clk;

    frac_clk_pacer dut_i (
        .clk      (clk),
        .rst      (rst),
        .div_int  (div_int),
        .div_frac (div_frac),
        .restart  (restart),
        .tick     (tick)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic pulse_restart();
        restart = 1'b1;
        step();
        restart = 1'b0;
        #0.5;
    endtask

    // Strobe times k*I + floor((k-1)*F/256) for k = 1, 2, ...
    task automatic run_cfg(input int i_val, input int f_val, input int ncyc, input string req);
        int k = 0;
        int next_t;
        int errs = 0;
        div_int  = 16'(i_val);
        div_frac = 8'(f_val);
        pulse_restart();
        next_t = i_val;
        for (int c = 1; c <= ncyc; c++) begin
            bit exp_t = (c == next_t);
            if (tick !== exp_t) errs++;
            if (exp_t) begin
                k++;
                next_t = (k + 1) * i_val + (k * f_val) / 256;
            end
            step();
        end
        check(errs == 0, req, errs, 0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        int first_t;
        int cnt_t;
        int errs;
        int t1;
        int t257;
        int k;
        rst      = 1'b1;
        restart  = 1'b0;
        div_int  = 16'd5;
        div_frac = 8'd0;
        step();
        step();
        // R8: tick low while reset is held
        check(tick == 1'b0, "R8 reset", int'(tick), 0);
        rst = 1'b0;
        #0.5;
        errs = 0;
        for (int c = 1; c <= 7; c++) begin
            if (tick !== (c == 5)) errs++;
            step();
        end
        // R8: first strobe 5 cycles after reset release
        check(errs == 0, "R8 first strobe", errs, 0);

        // R2: divide by one
        div_int = 16'd1; div_frac = 8'd0;
        pulse_restart();
        errs = 0;
        for (int c = 1; c <= 20; c++) begin
            if (tick !== 1'b1) errs++;
            step();
        end
        check(errs == 0, "R2 every cycle", errs, 0);

        // R1, R9: sweep of small whole parts over many fractions
        for (int i = 1; i <= 3; i++) begin
            for (int f = 0; f < 256; f += 17)
                run_cfg(i, f, 700, "R1 R9 sweep");
            run_cfg(i, 255, 700, "R1 R9 sweep");
        end
        run_cfg(7, 200, 900, "R1 large");

        // R3: 256 periods span 256*I + F
        div_int = 16'd3; div_frac = 8'd77;
        pulse_restart();
        k = 0; t1 = 0; t257 = 0;
        for (int c = 1; c <= 1000 && k < 257; c++) begin
            if (tick) begin
                k++;
                if (k == 1) t1 = c;
                if (k == 257) t257 = c;
            end
            step();
        end
        check((t257 - t1) == 256 * 3 + 77, "R3 span", t257 - t1, 256 * 3 + 77);

        // R6: restart coincides with a period end
        div_int = 16'd4; div_frac = 8'd0;
        pulse_restart();
        step(); step(); step();
        check(tick == 1'b1, "R6 due strobe", int'(tick), 1);
        restart = 1'b1;
        #0.5;
        check(tick == 1'b0, "R6 suppressed", int'(tick), 0);
        step();
        restart = 1'b0;
        #0.5;
        errs = 0;
        for (int c = 1; c <= 9; c++) begin
            if (tick !== (c == 4 || c == 8)) errs++;
            step();
        end
        check(errs == 0, "R6 realign", errs, 0);

        // R5: restart clears the accumulator (fraction 128 would carry on the second period)
        div_int = 16'd2; div_frac = 8'd128;
        pulse_restart();
        step(); step();
        pulse_restart();
        errs = 0;
        for (int c = 1; c <= 6; c++) begin
            if (tick !== (c == 2 || c == 4)) errs++;
            step();
        end
        check(errs == 0, "R5 restart phase", errs, 0);
        check(div_int == 16'd2 && div_frac == 8'd128, "R5 divisor kept", int'(div_int), 2);

        // R7: change divisor mid-period
        div_int = 16'd4; div_frac = 8'd0;
        pulse_restart();
        errs = 0;
        for (int c = 1; c <= 9; c++) begin
            if (c == 2) begin
                div_int = 16'd2;
                #0.5;
            end
            if (tick !== (c == 4 || c == 6 || c == 8)) errs++;
            step();
        end
        check(errs == 0, "R7 boundary", errs, 0);

        // R4: whole part 0 means 65536
        div_int = 16'd0; div_frac = 8'd0;
        pulse_restart();
        first_t = 0; cnt_t = 0;
        for (int c = 1; c <= 65540; c++) begin
            if (tick) begin
                cnt_t++;
                if (first_t == 0) first_t = c;
            end
            step();
        end
        check(first_t == 65536, "R4 first strobe", first_t, 65536);
        check(cnt_t == 1, "R4 strobe count", cnt_t, 1);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule